// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two tri-state byte buses, called A and B, and passes data across in one direction at a time. Each direction has its own holding register. The A-to-B register loads from the A bus on its own capture clock. The B-to-A register loads from the B bus on a second, independent capture clock. Neither capture clock is qualified by the enable or by the direction, so a register can load at any moment, including while both buses are isolated.

An active-low enable and a direction input decide which bus, if any, the block drives. When a bus is driven, a per-direction select picks its source. The source is either the live value on the opposite bus or the value held in that direction's register. If the held value is selected and the capture clock rises, the freshly loaded value appears on the driven bus. The block then acts as a clocked pass-through that also stores. A synchronous active-high reset, sampled on each capture clock, clears the holding register of that clock. The bus width is a parameter, and all bits behave identically.

Top module: `reg_bidir_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab` (with `rst` low), the A-to-B holding register takes the value present on `a_io` just before the edge.
- R2: On each rising edge of `clk_ba` (with `rst` low), the B-to-A holding register takes the value present on `b_io` just before the edge. This applies even when `b_io` is being driven by the block's own A side.
- R3: While `oe_n` is 1, the block drives neither bus, and both buses read back the values placed on them by external drivers.
- R4: While `oe_n` is 0 and `dir_to_b` is 1, the block drives `b_io` and leaves `a_io` as an input.
- R5: While `oe_n` is 0 and `dir_to_b` is 0, the block drives `a_io` and leaves `b_io` as an input.
- R6: A select input at 0 routes the live opposite-bus value to the driven bus. At 1 it routes that direction's holding register. `sel_ab_held` governs `b_io`, and `sel_ba_held` governs `a_io`.
- R7: Capture works regardless of `oe_n` and `dir_to_b`. Values loaded while isolated are later presented when held data is selected.
- R8: At no time does the block drive both buses. The bus that is not driven carries the external value unchanged.
- R9: When held data is selected for the driven bus and its capture clock rises, the driven bus shows the newly captured value after that edge.
- R10: A capture-clock edge with `rst` at 1 clears that clock's holding register to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B holding register |
| clk_ba | input | 1 | Capture clock of the B-to-A holding register |
| rst | input | 1 | Synchronous active-high clear, sampled on each capture clock |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_to_b | input | 1 | 1 drives the B bus from the A side; 0 drives the A bus from the B side |
| sel_ab_held | input | 1 | Source for the B bus: 0 live A, 1 held A-to-B register |
| sel_ba_held | input | 1 | Source for the A bus: 0 live B, 1 held B-to-A register |
| a_io | inout | WIDTH | A-side tri-state bus |
| b_io | inout | WIDTH | B-side tri-state bus |

## Verification
Directed steps first load distinct bytes into both registers while isolated. They then present each register on its own bus, which separates a wrong register, a wrong direction and a dead capture. A clocked pass-through step puts a new byte on A while held data is selected. This separates output taken after the edge from output taken before it. Further directed steps capture the B bus while the block itself drives it, and load after a reset. Random enable, direction, select, data and clock-pulse patterns then compare both buses before and after each edge. This catches swapped selects and a driver left on the input side.

// File: rtl/xcv_pkg.sv
`timescale 1ns/1ps
package xcv_pkg;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic to_a;
        logic to_b;
    } drive_t;

    localparam int NUM_PATHS = 2;
    localparam int PATH_AB   = 0;
    localparam int PATH_BA   = 1;

    function automatic drive_t decode_drive(input logic en_n, input logic toward_b);
        drive_t d;
        d.to_a = !en_n && !toward_b;
        d.to_b = !en_n &&  toward_b;
        return d;
    endfunction

    function automatic src_sel_e as_src(input logic s);
        return s ? SRC_HELD : SRC_LIVE;
    endfunction

endpackage

// File: rtl/hold_reg.sv
`timescale 1ns/1ps
module hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(d)));   // R1, R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (q == '0));          // R10

endmodule

// File: rtl/path_mux.sv
`timescale 1ns/1ps
module path_mux
    import xcv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  src_sel_e         sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        unique case (sel)
            SRC_HELD: y = held;
            default:  y = live;
        endcase
    end

endmodule

// File: rtl/drive_ctrl.sv
`timescale 1ns/1ps
module drive_ctrl
    import xcv_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir_to_b,
    output drive_t drv
);

    always_comb begin
        drv = decode_drive(oe_n, dir_to_b);
    end

    always_comb begin
        AST_SINGLE_SIDE: assert ($onehot0({drv.to_a, drv.to_b}));   // R8
    end

endmodule

// File: rtl/reg_bidir_xcvr.sv
`timescale 1ns/1ps
module reg_bidir_xcvr
    import xcv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir_to_b,
    input  logic             sel_ab_held,
    input  logic             sel_ba_held,
    inout  wire  [WIDTH-1:0] a_io,
    inout  wire  [WIDTH-1:0] b_io
);

    drive_t           drv;
    logic [WIDTH-1:0] path_in   [NUM_PATHS];
    logic [WIDTH-1:0] path_held [NUM_PATHS];
    logic [WIDTH-1:0] path_out  [NUM_PATHS];
    logic             path_clk  [NUM_PATHS];
    src_sel_e         path_sel  [NUM_PATHS];

    drive_ctrl u_drive (
        .oe_n     (oe_n),
        .dir_to_b (dir_to_b),
        .drv      (drv)
    );

    assign path_in[PATH_AB]  = a_io;
    assign path_in[PATH_BA]  = b_io;
    assign path_clk[PATH_AB] = clk_ab;
    assign path_clk[PATH_BA] = clk_ba;
    assign path_sel[PATH_AB] = as_src(sel_ab_held);
    assign path_sel[PATH_BA] = as_src(sel_ba_held);

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        hold_reg #(.WIDTH(WIDTH)) u_hold (
            .clk (path_clk[g]),
            .rst (rst),
            .d   (path_in[g]),
            .q   (path_held[g])
        );
        path_mux #(.WIDTH(WIDTH)) u_mux (
            .sel  (path_sel[g]),
            .live (path_in[g]),
            .held (path_held[g]),
            .y    (path_out[g])
        );
    end

    assign b_io = drv.to_b ? path_out[PATH_AB] : {WIDTH{1'bz}};
    assign a_io = drv.to_a ? path_out[PATH_BA] : {WIDTH{1'bz}};

    AST_B_SHOWS_HELD: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_n && dir_to_b && sel_ab_held) |-> (b_io == path_held[PATH_AB]));   // R6

    AST_A_SHOWS_HELD: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_n && !dir_to_b && sel_ba_held) |-> (a_io == path_held[PATH_BA]));  // R6

    AST_A_FOLLOWS_B: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_n && !dir_to_b && !sel_ba_held) |-> (a_io == b_io));               // R5

endmodule

// File: tb/test_reg_bidir_xcvr.sv
`timescale 1ns/1ps
module test_reg_bidir_xcvr;

    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
    logic         oe_n = 1'b1, dir_to_b = 1'b0, sab = 1'b0, sba = 1'b0;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic [W-1:0] m_qab = '0, m_qba = '0;
    wire  [W-1:0] a_bus, b_bus;
    int           total = 0, fails = 0;
    bit           done = 1'b0;

    assign a_bus = (oe_n ||  dir_to_b) ? ext_a : {W{1'bz}};
    assign b_bus = (oe_n || !dir_to_b) ? ext_b : {W{1'bz}};

    reg_bidir_xcvr #(.WIDTH(W)) i_reg_bidir_xcvr (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n),
        .dir_to_b(dir_to_b), .sel_ab_held(sab), .sel_ba_held(sba),
        .a_io(a_bus), .b_io(b_bus)
    );

    function automatic logic [W-1:0] exp_a();
        if (!oe_n && !dir_to_b) return sba ? m_qba : ext_b;
        return ext_a;
    endfunction

    function automatic logic [W-1:0] exp_b();
        if (!oe_n && dir_to_b) return sab ? m_qab : ext_a;
        return ext_b;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_buses(input string tag);
        string ta, tb;
        if (!oe_n && !dir_to_b)     begin ta = "R5"; tb = "R8"; end
        else if (!oe_n && dir_to_b) begin ta = "R8"; tb = "R4"; end
        else                        begin ta = "R3"; tb = "R3"; end
        if (tag != "") begin ta = tag; tb = tag; end
        chk(ta, a_bus, exp_a());
        chk(tb, b_bus, exp_b());
    endtask

    task automatic step(input logic o, input logic d, input logic s1, input logic s2,
                        input logic [W-1:0] ea, input logic [W-1:0] eb,
                        input logic pab, input logic pba, input string tag);
        logic [W-1:0] na, nb;
        string ptag;
        @(negedge clk);
        clk_ab = 1'b0; clk_ba = 1'b0;
        oe_n = o; dir_to_b = d; sab = s1; sba = s2; ext_a = ea; ext_b = eb;
        #1 check_buses(tag);
        @(posedge clk);
        na = exp_a(); nb = exp_b();
        if (pab) m_qab = rst ? '0 : na;
        if (pba) m_qba = rst ? '0 : nb;
        clk_ab = pab; clk_ba = pba;
        ptag = tag;
        if (ptag == "" && ((pab && !o && d && s1) || (pba && !o && !d && s2))) ptag = "R9";
        #1 check_buses(ptag);
    endtask

    initial begin
        void'($urandom(32'h5EED_0646));
        // R10: clear both registers, then present each
        rst = 1'b1;
        step(1, 0, 0, 0, 8'hFF, 8'hEE, 1, 1, "R10");
        rst = 1'b0;
        step(0, 1, 1, 0, 8'h11, 8'h22, 0, 0, "R10");
        step(0, 0, 0, 1, 8'h33, 8'h44, 0, 0, "R10");
        // R7: capture during isolation, then show held data
        step(1, 0, 1, 1, 8'h5A, 8'hC3, 1, 1, "R7");
        step(0, 1, 1, 0, 8'h00, 8'h99, 0, 0, "R7");
        step(0, 0, 0, 1, 8'h66, 8'h00, 0, 0, "R7");
        // R6: live path both directions
        step(0, 1, 0, 1, 8'hA5, 8'h0F, 0, 0, "R6");
        step(0, 0, 1, 0, 8'h3C, 8'h81, 0, 0, "R6");
        // R1 and R9: clock-through with held data selected
        step(0, 1, 1, 0, 8'h77, 8'h12, 1, 0, "R9");
        step(0, 1, 1, 0, 8'h00, 8'h12, 0, 0, "R1");
        // R2: capture B while the block drives B from live A
        step(0, 1, 0, 0, 8'hD2, 8'h00, 0, 1, "R2");
        step(0, 0, 0, 1, 8'h01, 8'h02, 0, 0, "R2");
        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic o;
            o = ($urandom % 4) == 0;
            step(o, 1'($urandom), 1'($urandom), 1'($urandom),
                 W'($urandom), W'($urandom), 1'($urandom), 1'($urandom), "");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule